// File: doc/BRIEF.md
# Multi-Lane Latency Aligner with Sample-Index Checking

This block sits where several parallel pipelined paths of a core have to meet again with their samples lined up in time. Each lane carries a data word, a valid bit and a sideband sample index. The index is a wrapping counter that is stamped on each sample when it enters the core. Every lane goes through its own delay line, and the depth of each line is a per-lane parameter. The data, valid bit and index leave that line together.

Behind the delay lines, a comparator looks at the sample indices on every cycle in which all lanes are valid, for the whole run. Two modes are chosen at run time by `verify_en`. In report mode the comparator keeps, for each lane, its signed index offset from lane 0, and it raises a sticky flag if those offsets ever move. In verify mode any disagreement among the indices raises a one-cycle pulse and a sticky error. The error stays set until reset.

A parameter removes all index storage and checking. That build is a set of plain data delay lines.

Top module: `lat_align`

## Requirements
- R1: Lane i delays its valid bit, data word and sample index by exactly D_i clock cycles. D_i is taken from bits [i*DEPTH_W +: DEPTH_W] of `LANE_DELAY`. A depth of 0 passes the lane through in the same cycle, and the default `LANE_DELAY` is all zeros.
- R2: A synchronous active-high reset clears every lane's delayed valid bits, `err_sticky`, `err_pulse`, `offset_changed` and every `offset` field to 0.
- R3: Sample indices are compared only in cycles where every `out_valid` bit is 1. If any lane is invalid, misaligned indices raise no error.
- R4: When `verify_en`=1 and all lanes are valid with indices that are not all equal, `err_pulse` is 1 in the following cycle. It is 1 once for each such cycle and 0 otherwise.
- R5: `err_sticky` goes to 1 together with the first `err_pulse` and then stays 1 until reset.
- R6: On each all-valid cycle, `offset` field i (bits [i*MARK_W +: MARK_W]) is loaded with (index_i − index_0) mod 2^MARK_W. The value is read as two's complement, so lane 0 always reads 0. When `verify_en`=0, no error is raised.
- R7: `offset_changed` goes to 1 when an all-valid cycle after the first one since reset yields offsets that differ from the stored ones. It then holds until reset.
- R8: Indices wrap modulo 2^MARK_W. Aligned lanes whose indices pass through the wrap raise no error.
- R9: With `MARK_EN`=0, data and valid are still delayed per R1. `out_mark`, `offset`, `offset_changed`, `err_sticky` and `err_pulse` are all constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| verify_en | input | 1 | 1 = verify mode, 0 = report mode |
| in_valid | input | NUM_LANES | Per-lane input valid |
| in_data | input | NUM_LANES*DATA_W | Per-lane input data, lane i at [i*DATA_W +: DATA_W] |
| in_mark | input | NUM_LANES*MARK_W | Per-lane sample index, lane i at [i*MARK_W +: MARK_W] |
| out_valid | output | NUM_LANES | Delayed per-lane valid |
| out_data | output | NUM_LANES*DATA_W | Delayed per-lane data |
| out_mark | output | NUM_LANES*MARK_W | Delayed per-lane sample index |
| offset | output | NUM_LANES*MARK_W | Registered signed index offset of each lane from lane 0 |
| offset_changed | output | 1 | Sticky flag: the offsets moved during the run |
| err_sticky | output | 1 | Sticky misalignment error |
| err_pulse | output | 1 | One-cycle misalignment pulse |

## Verification
The bench feeds three lanes with unequal delays from upstream skews. In the aligned case the total latency is the same on every lane. It then perturbs one lane's skew in verify mode: a comparator that only examined the first valid sample would miss this mismatch, and a non-sticky error would drop once alignment returns. A run whose indices cross the 8-bit wrap catches comparisons that treat the wrapped value as a real offset. Holding one lane invalid while the indices are misaligned catches a comparator that ignores the valid bits. The report-mode offsets are checked for a negative value, so a design that used unsigned or swapped subtraction would show the wrong sign. A second build without index logic, and a third with default parameters, confirm that the data still passes through with the right delay and that the flags stay silent.

// File: rtl/lat_align_pkg.sv
`timescale 1ns/1ps
package lat_align_pkg;

  typedef enum logic {
    CHK_REPORT = 1'b0,
    CHK_VERIFY = 1'b1
  } chk_mode_e;

  // Bits needed to hold a lane depth in 0..max_depth.
  function automatic int depth_bits(input int max_depth);
    return (max_depth < 1) ? 1 : $clog2(max_depth + 1);
  endfunction

endpackage

// File: rtl/lat_align_lane.sv
`timescale 1ns/1ps
// Fixed-depth delay line for one lane: valid plus a packed word.
module lat_align_lane #(
  parameter int DEPTH = 0,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  output logic [W-1:0] out_word
);

  if (DEPTH == 0) begin : g_thru
    logic unused_ctl;
    assign unused_ctl = clk ^ rst;
    assign out_valid  = in_valid;
    assign out_word   = in_word;
  end else begin : g_pipe
    logic [W-1:0]     word_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    // Word stages carry no reset so they map onto shift-register resources.
    always_ff @(posedge clk) begin
      word_q[0] <= in_word;
      for (int k = 1; k < DEPTH; k++) word_q[k] <= word_q[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
      end else begin
        vld_q[0] <= in_valid;
        for (int k = 1; k < DEPTH; k++) vld_q[k] <= vld_q[k-1];
      end
    end

    assign out_valid = vld_q[DEPTH-1];
    assign out_word  = word_q[DEPTH-1];
  end

endmodule

// File: rtl/lat_align_cmp.sv
`timescale 1ns/1ps
// Compares the delayed sample indices of all lanes on every all-valid cycle.
module lat_align_cmp
  import lat_align_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int MARK_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        verify_en,
  input  logic [NUM_LANES-1:0]        lane_valid,
  input  logic [NUM_LANES*MARK_W-1:0] lane_mark,
  output logic [NUM_LANES*MARK_W-1:0] offset,
  output logic                        offset_changed,
  output logic                        err_sticky,
  output logic                        err_pulse
);

  chk_mode_e                   mode;
  logic                        all_valid;
  logic                        mismatch;
  logic                        moved;
  logic                        have_ref_q;
  logic [NUM_LANES*MARK_W-1:0] diff;

  assign mode      = chk_mode_e'(verify_en);
  assign all_valid = &lane_valid;

  // Modular subtraction keeps wrapped indices comparable.
  always_comb begin
    mismatch = 1'b0;
    moved    = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      diff[i*MARK_W +: MARK_W] = lane_mark[i*MARK_W +: MARK_W] - lane_mark[0 +: MARK_W];
      if (diff[i*MARK_W +: MARK_W] != '0) mismatch = 1'b1;
      if (diff[i*MARK_W +: MARK_W] != offset[i*MARK_W +: MARK_W]) moved = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offset         <= '0;
      offset_changed <= 1'b0;
      have_ref_q     <= 1'b0;
      err_sticky     <= 1'b0;
      err_pulse      <= 1'b0;
    end else begin
      err_pulse <= 1'b0;
      if (all_valid) begin
        offset     <= diff;
        have_ref_q <= 1'b1;
        if (have_ref_q && moved) offset_changed <= 1'b1;
        if (mode == CHK_VERIFY && mismatch) begin
          err_pulse  <= 1'b1;
          err_sticky <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lat_align.sv
`timescale 1ns/1ps
module lat_align
  import lat_align_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int DATA_W    = 8,
  parameter int MARK_W    = 8,
  parameter int MAX_DEPTH = 8,
  parameter bit MARK_EN   = 1'b1,
  parameter int DEPTH_W   = depth_bits(MAX_DEPTH),
  parameter logic [NUM_LANES*DEPTH_W-1:0] LANE_DELAY = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        verify_en,
  input  logic [NUM_LANES-1:0]        in_valid,
  input  logic [NUM_LANES*DATA_W-1:0] in_data,
  input  logic [NUM_LANES*MARK_W-1:0] in_mark,
  output logic [NUM_LANES-1:0]        out_valid,
  output logic [NUM_LANES*DATA_W-1:0] out_data,
  output logic [NUM_LANES*MARK_W-1:0] out_mark,
  output logic [NUM_LANES*MARK_W-1:0] offset,
  output logic                        offset_changed,
  output logic                        err_sticky,
  output logic                        err_pulse
);

  localparam int LW = DATA_W + (MARK_EN ? MARK_W : 0);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int D = int'(LANE_DELAY[i*DEPTH_W +: DEPTH_W]);
    logic [LW-1:0] w_in;
    logic [LW-1:0] w_out;

    if (MARK_EN) begin : g_mark
      assign w_in = {in_mark[i*MARK_W +: MARK_W], in_data[i*DATA_W +: DATA_W]};
      assign out_mark[i*MARK_W +: MARK_W] = w_out[LW-1 -: MARK_W];
    end else begin : g_plain
      assign w_in = in_data[i*DATA_W +: DATA_W];
      assign out_mark[i*MARK_W +: MARK_W] = '0;
    end

    assign out_data[i*DATA_W +: DATA_W] = w_out[DATA_W-1:0];

    lat_align_lane #(.DEPTH(D), .W(LW)) i_lane (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid[i]),
      .in_word  (w_in),
      .out_valid(out_valid[i]),
      .out_word (w_out)
    );
  end

  if (MARK_EN) begin : g_cmp
    lat_align_cmp #(.NUM_LANES(NUM_LANES), .MARK_W(MARK_W)) i_cmp (
      .clk           (clk),
      .rst           (rst),
      .verify_en     (verify_en),
      .lane_valid    (out_valid),
      .lane_mark     (out_mark),
      .offset        (offset),
      .offset_changed(offset_changed),
      .err_sticky    (err_sticky),
      .err_pulse     (err_pulse)
    );
  end else begin : g_nocmp
    logic unused_mark;
    assign unused_mark    = ^{in_mark, verify_en};
    assign offset         = '0;
    assign offset_changed = 1'b0;
    assign err_sticky     = 1'b0;
    assign err_pulse      = 1'b0;
  end

endmodule

// File: rtl/lat_align_chk.sv
`timescale 1ns/1ps
module lat_align_chk #(
  parameter int NUM_LANES = 3,
  parameter int MARK_W    = 8,
  parameter bit MARK_EN   = 1'b1
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        verify_en,
  input logic [NUM_LANES-1:0]        out_valid,
  input logic [NUM_LANES*MARK_W-1:0] out_mark,
  input logic [NUM_LANES*MARK_W-1:0] offset,
  input logic                        offset_changed,
  input logic                        err_sticky,
  input logic                        err_pulse
);

  logic lanes_differ;
  always_comb begin
    lanes_differ = 1'b0;
    for (int i = 1; i < NUM_LANES; i++)
      if (out_mark[i*MARK_W +: MARK_W] != out_mark[0 +: MARK_W]) lanes_differ = 1'b1;
  end

  if (MARK_EN) begin : g_chk
    assert_pulse_sets_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      err_pulse |-> err_sticky);
    assert_sticky_holds_R5: assert property (@(posedge clk) disable iff (rst)
      err_sticky |=> err_sticky);
    assert_report_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      !verify_en |=> !err_pulse);
    assert_lane0_zero_R6: assert property (@(posedge clk) disable iff (rst)
      offset[MARK_W-1:0] == '0);
    assert_valid_gate_R3: assert property (@(posedge clk) disable iff (rst)
      !(&out_valid) |=> !err_pulse);
    assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (rst)
      (verify_en && (&out_valid) && lanes_differ) |=> err_pulse);
    assert_changed_holds_R7: assert property (@(posedge clk) disable iff (rst)
      offset_changed |=> offset_changed);
  end else begin : g_chk_nm
    assert_nomark_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !err_sticky && !err_pulse && !offset_changed && offset == '0 && out_mark == '0);
  end

endmodule

bind lat_align lat_align_chk #(
  .NUM_LANES(NUM_LANES),
  .MARK_W   (MARK_W),
  .MARK_EN  (MARK_EN)
) i_lat_align_chk (
  .clk           (clk),
  .rst           (rst),
  .verify_en     (verify_en),
  .out_valid     (out_valid),
  .out_mark      (out_mark),
  .offset        (offset),
  .offset_changed(offset_changed),
  .err_sticky    (err_sticky),
  .err_pulse     (err_pulse)
);

// File: tb/test_lat_align.sv
`timescale 1ns/1ps
module test_lat_align;

  localparam int N  = 3;
  localparam int DW = 8;
  localparam int MW = 8;
  // Lane depths: lane0 = 3, lane1 = 1, lane2 = 5
  localparam logic [11:0] DELAYS = {4'd5, 4'd1, 4'd3};
  localparam int DEP [N] = '{3, 1, 5};

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic verify_en = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*DW-1:0] in_data  = '0;
  logic [N*MW-1:0] in_mark  = '0;

  logic [N-1:0]    out_valid,  nm_valid,  df_valid;
  logic [N*DW-1:0] out_data,   nm_data,   df_data;
  logic [N*MW-1:0] out_mark,   nm_mark,   df_mark;
  logic [N*MW-1:0] offset,     nm_offset, df_offset;
  logic offset_changed, err_sticky, err_pulse;
  logic nm_changed, nm_sticky, nm_pulse;
  logic df_changed, df_sticky, df_pulse;

  always #2 clk = ~clk;

  lat_align #(.NUM_LANES(N), .DATA_W(DW), .MARK_W(MW), .MAX_DEPTH(8), .MARK_EN(1'b1),
              .LANE_DELAY(DELAYS)) i_lat_align (
    .clk(clk), .rst(rst), .verify_en(verify_en), .in_valid(in_valid), .in_data(in_data),
    .in_mark(in_mark), .out_valid(out_valid), .out_data(out_data), .out_mark(out_mark),
    .offset(offset), .offset_changed(offset_changed), .err_sticky(err_sticky),
    .err_pulse(err_pulse));

  lat_align #(.NUM_LANES(N), .DATA_W(DW), .MARK_W(MW), .MAX_DEPTH(8), .MARK_EN(1'b0),
              .LANE_DELAY(DELAYS)) i_lat_align_nm (
    .clk(clk), .rst(rst), .verify_en(verify_en), .in_valid(in_valid), .in_data(in_data),
    .in_mark(in_mark), .out_valid(nm_valid), .out_data(nm_data), .out_mark(nm_mark),
    .offset(nm_offset), .offset_changed(nm_changed), .err_sticky(nm_sticky),
    .err_pulse(nm_pulse));

  lat_align i_lat_align_dflt (
    .clk(clk), .rst(rst), .verify_en(verify_en), .in_valid(in_valid), .in_data(in_data),
    .in_mark(in_mark), .out_valid(df_valid), .out_data(df_data), .out_mark(df_mark),
    .offset(df_offset), .offset_changed(df_changed), .err_sticky(df_sticky),
    .err_pulse(df_pulse));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [7:0] cnt = '0;
  logic [7:0] skew [N];
  logic [N-1:0] vmask = '0;
  int warm = 0;

  function automatic logic [7:0] key(input int i);
    return 8'h5A + 8'(i * 37);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: new inputs after the edge, outputs sampled at the falling edge.
  task automatic drive_cycle();
    @(posedge clk);
    #1;
    cnt = cnt + 8'd1;
    for (int i = 0; i < N; i++) begin
      logic [7:0] m;
      m = cnt - skew[i];
      in_mark[i*MW +: MW] = m;
      in_data[i*DW +: DW] = m ^ key(i);
    end
    in_valid = vmask;
    warm++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    rst = 1'b1;
    vmask = '0;
    in_valid = '0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    cnt = '0;
    warm = 0;
    @(negedge clk);
  endtask

  // R1: lane i output index equals input index D_i cycles back; data follows it.
  task automatic check_stream();
    if (warm > 6) begin
      for (int i = 0; i < N; i++) begin
        logic [7:0] em;
        em = cnt - 8'(DEP[i]) - skew[i];
        check("R1 lane index", 32'(out_mark[i*MW +: MW]), 32'(em));
        check("R1 lane data", 32'(out_data[i*DW +: DW]), 32'(em ^ key(i)));
        check("R9 data without index logic", 32'(nm_data[i*DW +: DW]), 32'(em ^ key(i)));
      end
      check("R1 valid", 32'(out_valid), 32'(vmask));
    end
    check("R1 default depth zero", 32'(df_mark), 32'(in_mark));
  endtask

  task automatic t_reset();
    do_reset();
    check("R2 out_valid", 32'(out_valid), 32'd0);
    check("R2 err_sticky", 32'(err_sticky), 32'd0);
    check("R2 err_pulse", 32'(err_pulse), 32'd0);
    check("R2 offset_changed", 32'(offset_changed), 32'd0);
    check("R2 offset", 32'(offset), 32'd0);
  endtask

  task automatic t_aligned();
    do_reset();
    skew[0] = 8'd2; skew[1] = 8'd4; skew[2] = 8'd0;
    verify_en = 1'b1;
    vmask = '1;
    repeat (20) begin
      drive_cycle();
      check_stream();
      check("R4 no pulse when aligned", 32'(err_pulse), 32'd0);
    end
    check("R4 no error when aligned", 32'(err_sticky), 32'd0);
    check("R6 offsets zero when aligned", 32'(offset), 32'd0);
  endtask

  task automatic t_report();
    do_reset();
    skew[0] = 8'd0; skew[1] = 8'd0; skew[2] = 8'd0;
    verify_en = 1'b0;
    vmask = '1;
    repeat (20) begin
      drive_cycle();
      check_stream();
    end
    check("R6 offset lane1", 32'(offset[1*MW +: MW]), 32'h02);
    check("R6 offset lane2 negative", 32'(offset[2*MW +: MW]), 32'hFE);
    check("R6 lane0 zero", 32'(offset[0 +: MW]), 32'h00);
    check("R6 no error in report mode", 32'(err_sticky), 32'd0);
    check("R7 no change on steady stream", 32'(offset_changed), 32'd0);
    skew[1] = 8'd3;
    warm = 0;
    repeat (12) drive_cycle();
    check("R7 change flagged", 32'(offset_changed), 32'd1);
    check("R6 moved offset lane1", 32'(offset[1*MW +: MW]), 32'hFF);
  endtask

  task automatic t_mismatch();
    int pulses;
    do_reset();
    skew[0] = 8'd2; skew[1] = 8'd4; skew[2] = 8'd0;
    verify_en = 1'b1;
    vmask = '1;
    repeat (10) drive_cycle();
    check("R4 clean before skew", 32'(err_sticky), 32'd0);
    skew[2] = 8'd1;
    pulses = 0;
    repeat (12) begin
      drive_cycle();
      if (err_pulse) pulses++;
    end
    check("R4 pulse while misaligned", 32'(err_pulse), 32'd1);
    check("R4 pulse on later cycles", 32'(pulses > 3), 32'd1);
    check("R5 sticky set", 32'(err_sticky), 32'd1);
    skew[2] = 8'd0;
    repeat (12) drive_cycle();
    check("R4 pulse clears once realigned", 32'(err_pulse), 32'd0);
    check("R5 sticky holds", 32'(err_sticky), 32'd1);
    check("R9 no error without index logic", 32'({nm_sticky, nm_pulse, nm_changed}), 32'd0);
    check("R9 index and offset zero", 32'(nm_mark | nm_offset), 32'd0);
    do_reset();
    check("R5 sticky cleared by reset", 32'(err_sticky), 32'd0);
  endtask

  task automatic t_wrap();
    do_reset();
    skew[0] = 8'd2; skew[1] = 8'd4; skew[2] = 8'd0;
    verify_en = 1'b1;
    vmask = '1;
    cnt = 8'd230;
    repeat (45) begin
      drive_cycle();
      check_stream();
    end
    check("R8 no error across wrap", 32'(err_sticky), 32'd0);
    check("R8 offsets zero across wrap", 32'(offset), 32'd0);
  endtask

  task automatic t_valid_gate();
    do_reset();
    skew[0] = 8'd0; skew[1] = 8'd0; skew[2] = 8'd0;
    verify_en = 1'b1;
    vmask = 3'b101;
    repeat (15) drive_cycle();
    check("R3 lane1 invalid", 32'(out_valid), 32'b101);
    check("R3 no error with a lane invalid", 32'(err_sticky), 32'd0);
    vmask = 3'b111;
    repeat (10) drive_cycle();
    check("R3 error once all lanes valid", 32'(err_sticky), 32'd1);
  endtask

  initial begin
    skew[0] = '0; skew[1] = '0; skew[2] = '0;
    t_reset();
    t_aligned();
    t_report();
    t_mismatch();
    t_wrap();
    t_valid_gate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule